// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block holds four general registers that share one internal data bus. A 4-bit instruction word names a source register and a destination register. The source field is decoded into a one-hot enable, and only the enabled register drives the bus. The destination field is decoded into a one-hot load enable. Every term of that load decoder is gated by a common transfer strobe. The bus value reaches all four registers, but only the selected one captures it, and it does so on the clock edge where the strobe is high. The source register is left as it was.

A second mode uses the same instruction. The source field picks the register that drives operand bus A, and a separate two-bit select picks the register that drives operand bus B. A small ALU combines the two operands. The destination register takes the ALU result, and registered carry and overflow flags are updated. An external load port can preset any register directly, and a synchronous reset clears every register and both flags.

Top module: `regxfer_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four registers and both flags become zero at that edge.
- R2: Instruction bits [1:0] select the register that drives the shared bus (operand bus A), using 00=reg0, 01=reg1, 10=reg2 and 11=reg3. At most one register drives each bus in any cycle.
- R3: Instruction bits [3:2] select the destination register, using the same encoding. On a transfer, only that register changes and the other three keep their values.
- R4: When `xfer` is low and `ext_we` is low at a clock edge, no register and no flag changes.
- R5: In move mode (`mode`=0), when `xfer` is high the destination register takes the value the source register held before the edge. The source register keeps its value.
- R6: When `ext_we` is high, `ext_data` is written into the register named by `ext_sel` (same encoding as R2). In that cycle `xfer` is ignored: no move or ALU write takes place and the flags hold.
- R7: In ALU mode (`mode`=1) with `xfer` high, the destination takes f(A,B). A is the register named by bits [1:0] and B is the register named by `srcb_sel`. The `alu_fn` codes are: 000 gives A+B, 001 gives A-B, 010 gives A AND B, 011 gives A OR B, 100 gives A XOR B, and 101 to 111 pass A through.
- R8: On an ALU transfer, `flag_c` takes the carry out of the MSB. For add this is the carry out of A+B. For subtract, which is formed as A+~B+1, it is 1 exactly when A>=B unsigned. For all other codes it is 0. Moves leave both flags unchanged.
- R9: On an ALU transfer, `flag_v` takes the two's-complement overflow of add or subtract, which is the XOR of the carry into and the carry out of the MSB. For all other codes it is 0.
- R10: A move whose source equals its destination leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 4 | [3:2] destination, [1:0] source / operand A |
| xfer | input | 1 | Transfer strobe qualifying the destination write |
| mode | input | 1 | 0 = move, 1 = ALU operation |
| srcb_sel | input | 2 | Register that drives operand bus B |
| alu_fn | input | 3 | ALU function code |
| ext_we | input | 1 | External load enable |
| ext_sel | input | 2 | Register written by the external load |
| ext_data | input | 8 | External load value |
| regs_o | output | 32 | Register contents, reg k at bits [8k+7:8k] |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The moves cover distinct source and destination pairs, including a source that equals its destination. These show whether the source decoder, the destination decoder and the bus mux are wired to the right indices. The ALU cases use operands that sit on the sign and carry boundaries: 7F+01, FF+01, 10-20, 80-01, and A and B taken from the same register. Together they separate carry from overflow and show the borrow sense of subtract. Directed cycles with the strobe low, with the external load and the strobe high together, and with a move after a flag-setting operation show that writes and flags are gated as required.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;
  localparam logic [2:0] FN_ADD = 3'd0;
  localparam logic [2:0] FN_SUB = 3'd1;
  localparam logic [2:0] FN_AND = 3'd2;
  localparam logic [2:0] FN_OR  = 3'd3;
  localparam logic [2:0] FN_XOR = 3'd4;

  typedef enum logic {XF_MOVE = 1'b0, XF_ALU = 1'b1} xfer_mode_e;
endpackage

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int SEL_W = 2,
  localparam int N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic [N-1:0]     hot
);
  for (genvar k = 0; k < N; k++) begin : g_term
    assign hot[k] = en && (sel == SEL_W'(k));
  end
endmodule

// File: rtl/onehot_mux.sv
module onehot_mux #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N-1:0]   en,
  input  logic [N*W-1:0] din,
  output logic [W-1:0]   dout
);
  always_comb begin
    dout = '0;
    for (int k = 0; k < N; k++) begin
      dout = dout | (din[k*W +: W] & {W{en[k]}});
    end
  end
endmodule

// File: rtl/xfer_alu.sv
module xfer_alu
  import regxfer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         c,
  output logic         v
);
  typedef struct packed {
    logic [W-1:0] res;
    logic         cout;
    logic         ovf;
  } alu_out_t;

  function automatic alu_out_t add_core(input logic [W-1:0] x,
                                        input logic [W-1:0] z,
                                        input logic         cin);
    alu_out_t o;
    logic [W-1:0] low;
    logic [W:0]   full;
    low    = {1'b0, x[W-2:0]} + {1'b0, z[W-2:0]} + W'(cin);
    full   = {1'b0, x} + {1'b0, z} + (W+1)'(cin);
    o.res  = full[W-1:0];
    o.cout = full[W];
    o.ovf  = low[W-1] ^ full[W];
    return o;
  endfunction

  alu_out_t r;
  always_comb begin
    r = '0;
    case (fn)
      FN_ADD:  r = add_core(a, b, 1'b0);
      FN_SUB:  r = add_core(a, ~b, 1'b1);
      FN_AND:  r.res = a & b;
      FN_OR:   r.res = a | b;
      FN_XOR:  r.res = a ^ b;
      default: r.res = a;
    endcase
  end

  assign y = r.res;
  assign c = r.cout;
  assign v = r.ovf;
endmodule

// File: rtl/regxfer_unit.sv
module regxfer_unit
  import regxfer_pkg::*;
#(
  parameter int W     = 8,
  parameter int SEL_W = 2,
  localparam int NREG = 1 << SEL_W,
  localparam int IW   = 2 * SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    instr,
  input  logic             xfer,
  input  logic             mode,
  input  logic [SEL_W-1:0] srcb_sel,
  input  logic [2:0]       alu_fn,
  input  logic             ext_we,
  input  logic [SEL_W-1:0] ext_sel,
  input  logic [W-1:0]     ext_data,
  output logic [NREG*W-1:0] regs_o,
  output logic             flag_c,
  output logic             flag_v
);
  logic [SEL_W-1:0] src_f, dst_f;
  logic [NREG-1:0]  src_a_en, src_b_en, dst_ld, ext_ld;
  logic [W-1:0]     bus_a, bus_b, alu_y, wr_data;
  logic             alu_c, alu_v, xfer_ok;
  logic [W-1:0]     rf [NREG];
  logic [NREG*W-1:0] rf_flat;
  xfer_mode_e       op_mode;

  assign src_f   = instr[SEL_W-1:0];
  assign dst_f   = instr[IW-1:SEL_W];
  assign xfer_ok = xfer && !ext_we;
  assign op_mode = xfer_mode_e'(mode);

  onehot_dec #(.SEL_W(SEL_W)) u_src_a (.sel(src_f),    .en(1'b1),    .hot(src_a_en));
  onehot_dec #(.SEL_W(SEL_W)) u_src_b (.sel(srcb_sel), .en(1'b1),    .hot(src_b_en));
  onehot_dec #(.SEL_W(SEL_W)) u_dst   (.sel(dst_f),    .en(xfer_ok), .hot(dst_ld));
  onehot_dec #(.SEL_W(SEL_W)) u_ext   (.sel(ext_sel),  .en(ext_we),  .hot(ext_ld));

  onehot_mux #(.N(NREG), .W(W)) u_bus_a (.en(src_a_en), .din(rf_flat), .dout(bus_a));
  onehot_mux #(.N(NREG), .W(W)) u_bus_b (.en(src_b_en), .din(rf_flat), .dout(bus_b));

  xfer_alu #(.W(W)) u_alu (
    .fn(alu_fn), .a(bus_a), .b(bus_b), .y(alu_y), .c(alu_c), .v(alu_v)
  );

  assign wr_data = (op_mode == XF_ALU) ? alu_y : bus_a;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            rf[k] <= '0;
      else if (ext_ld[k]) rf[k] <= ext_data;
      else if (dst_ld[k]) rf[k] <= wr_data;
    end
    assign rf_flat[k*W +: W] = rf[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else if (xfer_ok && op_mode == XF_ALU) begin
      flag_c <= alu_c;
      flag_v <= alu_v;
    end
  end

  assign regs_o = rf_flat;
endmodule

// File: rtl/regxfer_chk.sv
module regxfer_chk #(
  parameter int W     = 8,
  parameter int SEL_W = 2,
  localparam int NREG = 1 << SEL_W,
  localparam int IW   = 2 * SEL_W
) (
  input logic              clk,
  input logic              rst,
  input logic [IW-1:0]     instr,
  input logic              xfer,
  input logic              mode,
  input logic              ext_we,
  input logic [NREG*W-1:0] regs_o,
  input logic              flag_c,
  input logic              flag_v,
  input logic [NREG-1:0]   src_a_en,
  input logic [NREG-1:0]   src_b_en,
  input logic [NREG-1:0]   dst_ld
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (regs_o == '0 && !flag_c && !flag_v)); // R1
  AST_BUS_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (rst) $onehot0(src_a_en) && $onehot0(src_b_en)); // R2
  AST_DEST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (rst) $onehot0(dst_ld)); // R3
  AST_STROBE_GATES_LOAD: assert property (@(posedge clk) disable iff (rst) !xfer |-> dst_ld == '0); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!xfer && !ext_we) |=> ($stable(regs_o) && $stable(flag_c) && $stable(flag_v))); // R4
  AST_MOVE_COPIES: assert property (@(posedge clk) disable iff (rst)
    (xfer && !mode && !ext_we) |=>
      regs_o[int'($past(instr[IW-1:SEL_W]))*W +: W] == $past(regs_o[int'(instr[SEL_W-1:0])*W +: W])); // R5
  AST_MOVE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (xfer && !mode) |=> ($stable(flag_c) && $stable(flag_v))); // R8
endmodule

bind regxfer_unit regxfer_chk #(.W(W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .instr(instr), .xfer(xfer), .mode(mode), .ext_we(ext_we),
  .regs_o(regs_o), .flag_c(flag_c), .flag_v(flag_v),
  .src_a_en(src_a_en), .src_b_en(src_b_en), .dst_ld(dst_ld)
);

// File: tb/sim_regxfer_unit.sv
module sim_regxfer_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  instr = '0;
  logic        xfer = 1'b0, mode = 1'b0, ext_we = 1'b0;
  logic [1:0]  srcb_sel = '0, ext_sel = '0;
  logic [2:0]  alu_fn = '0;
  logic [7:0]  ext_data = '0;
  logic [31:0] regs_o;
  logic        flag_c, flag_v;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mdl [4];
  logic       mc, mv;

  always #5 clk = ~clk;

  regxfer_unit u0 (
    .clk(clk), .rst(rst), .instr(instr), .xfer(xfer), .mode(mode), .srcb_sel(srcb_sel),
    .alu_fn(alu_fn), .ext_we(ext_we), .ext_sel(ext_sel), .ext_data(ext_data),
    .regs_o(regs_o), .flag_c(flag_c), .flag_v(flag_v)
  );

  typedef struct packed {
    logic       m;
    logic [3:0] ins;
    logic [1:0] sb;
    logic [2:0] fn;
    logic [7:0] a;
    logic [7:0] b;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'b0100, 2'd0, 3'd0, 8'h5A, 8'h00},
    '{1'b0, 4'b0011, 2'd0, 3'd0, 8'hC3, 8'h00},
    '{1'b0, 4'b1010, 2'd0, 3'd0, 8'h77, 8'h00},
    '{1'b0, 4'b1001, 2'd0, 3'd0, 8'h3C, 8'h00},
    '{1'b1, 4'b1100, 2'd1, 3'd0, 8'h7F, 8'h01},
    '{1'b1, 4'b0010, 2'd3, 3'd0, 8'hFF, 8'h01},
    '{1'b1, 4'b1101, 2'd2, 3'd1, 8'h10, 8'h20},
    '{1'b1, 4'b0111, 2'd0, 3'd1, 8'h80, 8'h01},
    '{1'b1, 4'b1000, 2'd1, 3'd2, 8'hF0, 8'h3C},
    '{1'b1, 4'b0110, 2'd0, 3'd3, 8'hA0, 8'h05},
    '{1'b1, 4'b1111, 2'd2, 3'd4, 8'hAA, 8'hFF},
    '{1'b1, 4'b1101, 2'd1, 3'd0, 8'h40, 8'h40},
    '{1'b1, 4'b0001, 2'd2, 3'd7, 8'h9E, 8'h11}
  };

  function automatic logic [31:0] mdl_flat();
    return {mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  // Reference ALU written from the requirement text (R7, R8, R9)
  task automatic ref_alu(input logic [2:0] fn, input logic [7:0] a, input logic [7:0] b,
                         output logic [7:0] y, output logic c, output logic v);
    int ua = a, ub = b, sa = $signed(a), sb = $signed(b), s;
    c = 1'b0; v = 1'b0;
    case (fn)
      3'd0: begin y = 8'(ua + ub); c = (ua + ub) > 255; s = sa + sb; v = (s > 127) || (s < -128); end
      3'd1: begin y = 8'(ua - ub); c = (ua >= ub);      s = sa - sb; v = (s > 127) || (s < -128); end
      3'd2: y = a & b;
      3'd3: y = a | b;
      3'd4: y = a ^ b;
      default: y = a;
    endcase
  endtask

  task automatic check_regs(input string tag);
    n_cmp++;
    if (regs_o !== mdl_flat()) begin
      n_bad++;
      $display("FAIL %s regs actual=%h expected=%h", tag, regs_o, mdl_flat());
    end
  endtask

  task automatic check_flags(input string tag);
    n_cmp++;
    if ({flag_c, flag_v} !== {mc, mv}) begin
      n_bad++;
      $display("FAIL %s flags c/v actual=%b%b expected=%b%b", tag, flag_c, flag_v, mc, mv);
    end
  endtask

  task automatic ext_load(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    ext_we = 1'b1; ext_sel = sel; ext_data = d;
    @(negedge clk);
    ext_we = 1'b0;
    mdl[sel] = d;
  endtask

  task automatic issue(input logic m, input logic [3:0] ins, input logic [1:0] sb, input logic [2:0] fn);
    logic [7:0] y;
    logic c, v;
    @(negedge clk);
    xfer = 1'b1; mode = m; instr = ins; srcb_sel = sb; alu_fn = fn;
    @(negedge clk);
    xfer = 1'b0;
    if (m) begin
      ref_alu(fn, mdl[ins[1:0]], mdl[sb], y, c, v);
      mdl[ins[3:2]] = y; mc = c; mv = v;
    end else begin
      mdl[ins[3:2]] = mdl[ins[1:0]];
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) mdl[k] = '0;
    mc = 1'b0; mv = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_regs("R1 reset");
    check_flags("R1 reset");

    for (int i = 0; i < NV; i++) begin
      ext_load(VECS[i].ins[1:0], VECS[i].a);
      if (VECS[i].m) ext_load(VECS[i].sb, VECS[i].b);
      issue(VECS[i].m, VECS[i].ins, VECS[i].sb, VECS[i].fn);
      if (VECS[i].m)
        check_regs($sformatf("R7 R2 vec%0d", i));
      else if (VECS[i].ins[3:2] == VECS[i].ins[1:0])
        check_regs($sformatf("R10 vec%0d", i));
      else
        check_regs($sformatf("R5 R3 R2 vec%0d", i));
      check_flags($sformatf("R8 R9 vec%0d", i));
    end

    // R4: strobe low, instruction present, nothing changes
    ext_load(2'd0, 8'hE1);
    @(negedge clk);
    instr = 4'b1100; mode = 1'b0; xfer = 1'b0;
    repeat (2) @(negedge clk);
    check_regs("R4 no strobe");
    check_flags("R4 no strobe");

    // R8: set carry through ALU, then a move must leave flags alone
    ext_load(2'd1, 8'hFF);
    ext_load(2'd2, 8'h01);
    issue(1'b1, 4'b0001, 2'd2, 3'd0);
    check_flags("R8 carry set");
    issue(1'b0, 4'b1101, 2'd0, 3'd0);
    check_flags("R8 move keeps flags");
    check_regs("R5 move after alu");

    // R6: external load wins over a simultaneous transfer
    @(negedge clk);
    ext_we = 1'b1; ext_sel = 2'd2; ext_data = 8'h11;
    xfer = 1'b1; mode = 1'b1; instr = 4'b1100; srcb_sel = 2'd0; alu_fn = 3'd0;
    @(negedge clk);
    ext_we = 1'b0; xfer = 1'b0;
    mdl[2] = 8'h11;
    check_regs("R6 ext priority");
    check_flags("R6 flags hold");

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) mdl[k] = '0;
    mc = 1'b0; mv = 1'b0;
    check_regs("R1 mid reset");
    check_flags("R1 mid reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule